// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

This block is a register-to-register synchronous static memory with a pipelined read path. Every control input is sampled on the rising clock edge. A selected read registers its address on one edge. The word then leaves through an output register after the next edge. A write stores the data presented on the same edge as its address. Each of four byte lanes can be written on its own, or a single global write control can force all four lanes together.

Three chip selects must all be in their active state together before the core does anything, so several cores can share an address bus for depth expansion. The output bus has two releases. A deselect lets the bus stay driven for one extra cycle before it goes to high impedance. The output enable releases the bus at once, with no clock edge needed. A sleep input blocks every read and write while it is held high.

The bidirectional data bus is modelled as a data-in port, a data-out port and an output-valid flag. The valid flag stands for "the core drives the bus". The read stream has no ready signal, because a memory array cannot stall. A consumer must take each word in the cycle it is valid. The core never waits, and it never repeats a word for back-pressure.

Top module: `sync_pipe_sram`

## Requirements
- R1: After reset, `dout_valid` is low until a read has been launched.
- R2: An access happens only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at the same edge. With any other combination the edge writes nothing and launches no read.
- R3: A selected read sampled at edge k shows `dout_valid`=1 and the stored word on `dout` after edge k+1.
- R4: When `wr_all_n`=0 on a selected edge, all four lanes are written, whatever `lane_wr_en_n` and `lane_sel_n` are.
- R5: When `wr_all_n`=1, lane i is written only if `lane_wr_en_n`=0 and `lane_sel_n[i]`=0. Lane i occupies bits [i*L +: L], with lane 0 at bit 0. All other lanes keep their old contents.
- R6: A selected edge with `wr_all_n`=1 and with either `lane_wr_en_n`=1 or `lane_sel_n`=4'b1111 is a read.
- R7: If a read at edge k is followed by a deselect at edge k+1, the bus stays driven with the same word after edge k+2 and is released after edge k+3. If edge k+1 is a selected write instead, the bus is released after edge k+2.
- R8: `out_en_n`=1 forces `dout_valid` low at once, with no clock edge. Lowering `out_en_n` again brings back the pending word.
- R9: While `sleep`=1 at an edge, that edge writes nothing and launches no read.
- R10: A write at edge k followed by a read of the same address at edge k+1 returns the newly written word.
- R11: The lane width L is `WORD_W`/4. That is 9 bits for the 36-bit word and 8 bits for the 32-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline state (not the array) |
| addr | input | ADDR_W | Word address |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low, bit i = lane i |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power standby; blocks all accesses |
| din | input | WORD_W | Write data, sampled with the address |
| dout | output | WORD_W | Read data from the output register |
| dout_valid | output | 1 | High while the core drives the data bus |

## Verification
Most wrong internal states reach the ports within three edges. A broken select decode or sleep gate shows up as a word that changes when it should not, on the next read of that address. A missing stage register moves `dout_valid` one edge early or late, so the pipelined sweep catches it at the first read. A wrong hold register either drops the bus one cycle early or keeps it one cycle too long after a deselect or a write. A wrong lane mask or lane width corrupts exactly the lane that the byte-write sweep reads back.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } op_e;
endpackage

// File: rtl/sps_decode.sv
module sps_decode
  import sps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_all_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             sleep,
  output op_e              op_o,
  output logic [LANES-1:0] lane_we_o
);
  logic             chip_sel;
  logic [LANES-1:0] lane_req;

  assign chip_sel = ~sel_a_n & sel_b & ~sel_c_n;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_req[i] = ~wr_all_n | (~lane_wr_en_n & ~lane_sel_n[i]);
    end
    if (!chip_sel) begin
      op_o = OP_DESEL;
    end else if (sleep) begin
      op_o = OP_IDLE;
    end else if (|lane_req) begin
      op_o = OP_WRITE;
    end else begin
      op_o = OP_READ;
    end
    lane_we_o = (op_o == OP_WRITE) ? lane_req : '0;
  end

  // R4: the global write reaches every lane
  assert_global_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_sel && !sleep && !wr_all_n) |-> (&lane_we_o));

  // R2: no select means no write and no read
  assert_unselected_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_sel) |-> (lane_we_o == '0 && op_o != OP_READ));

  // R9: sleep blocks all accesses
  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we_o == '0 && op_o != OP_READ));
endmodule

// File: rtl/sps_array.sv
module sps_array
  import sps_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LANE_W = WORD_W / LANES;

  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              data_v_q;

  // address stage, then data stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      addr_q   <= '0;
      data_v_q <= 1'b0;
    end else begin
      rd_q     <= rd_i;
      if (rd_i) addr_q <= addr_i;
      data_v_q <= rd_q;
    end
  end

  assign rvalid_o = data_v_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (lane_we_i[g]) bank[addr_i] <= din_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lane_q <= '0;
      else if (rd_q) lane_q <= bank[addr_q];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = lane_q;
  end

  // R6: a write edge never also launches a read
  assert_write_not_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we_i != '0) |-> !rd_i);
endmodule

// File: rtl/sps_drive.sv
module sps_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic rvalid_i,
  input  logic desel_i,
  input  logic out_en_n_i,
  output logic drive_o,
  output logic valid_o
);
  logic desel_q;
  logic hold_q;

  // a deselect right after a read keeps the bus one extra cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desel_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      desel_q <= desel_i;
      hold_q  <= rvalid_i & desel_q;
    end
  end

  assign drive_o = rvalid_i | hold_q;
  assign valid_o = drive_o & ~out_en_n_i;

  // R8: a high output enable releases the bus at once
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n_i |-> !valid_o);
endmodule

// File: rtl/sync_pipe_sram.sv
module sync_pipe_sram
  import sps_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr_all_n,
  input  logic              lane_wr_en_n,
  input  logic [3:0]        lane_sel_n,
  input  logic              out_en_n,
  input  logic              sleep,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_valid
);
  op_e              op;
  logic [LANES-1:0] lane_we;
  logic             rvalid;
  logic             drive;

  sps_decode u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .wr_all_n     (wr_all_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .sleep        (sleep),
    .op_o         (op),
    .lane_we_o    (lane_we)
  );

  sps_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr),
    .din_i     (din),
    .lane_we_i (lane_we),
    .rd_i      (op == OP_READ),
    .rdata_o   (dout),
    .rvalid_o  (rvalid)
  );

  sps_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .rvalid_i   (rvalid),
    .desel_i    (op == OP_DESEL),
    .out_en_n_i (out_en_n),
    .drive_o    (drive),
    .valid_o    (dout_valid)
  );

  // R3: a read reaches the bus two edges after it is sampled
  assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |-> ##2 drive);

  // R7: a deselect after a read holds the bus one more cycle
  assert_deselect_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) ##1 (op == OP_DESEL) |-> ##2 drive);

  // R7: two edges without a read release the bus
  assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_READ) ##1 (op != OP_READ) |-> ##2 !drive);
endmodule

// File: tb/sync_pipe_sram_bench.sv
module sync_pipe_sram_bench;
  localparam int AW = 4;
  localparam int WW = 36;
  localparam int LW = WW / 4;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          wr_all_n, lane_wr_en_n;
  logic [3:0]    lane_sel_n;
  logic          out_en_n, sleep;
  logic [WW-1:0] din;
  logic [WW-1:0] dout;
  logic          dout_valid;

  logic [WW-1:0] model [NW];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sync_pipe_sram #(.ADDR_W(AW), .WORD_W(WW)) u_sync_pipe_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr_all_n(wr_all_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_sel_n(lane_sel_n), .out_en_n(out_en_n), .sleep(sleep), .din(din),
    .dout(dout), .dout_valid(dout_valid)
  );

  function automatic logic [WW-1:0] pat(input int a, input int s);
    logic [63:0] v;
    v = 64'(a + 1) * 64'h9E3779B1 + 64'(s) * 64'h314159265;
    return v[WW-1:0];
  endfunction

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    sel_a_n = 1'b1; sel_b = 1'b1; sel_c_n = 1'b0;
    wr_all_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 4'hF; sleep = 1'b0;
  endtask

  task automatic go_read(input int a);
    go_idle();
    sel_a_n = 1'b0; addr = AW'(a);
  endtask

  task automatic go_write(input int a, input logic g_n, input logic be_n,
                          input logic [3:0] m, input logic [WW-1:0] d);
    go_idle();
    sel_a_n = 1'b0; addr = AW'(a); din = d;
    wr_all_n = g_n; lane_wr_en_n = be_n; lane_sel_n = m;
    for (int l = 0; l < 4; l++) begin
      if (!g_n || (!be_n && !m[l])) model[a][l*LW +: LW] = d[l*LW +: LW];
    end
  endtask

  // back-to-back reads of every address
  task automatic sweep(input string req);
    for (int i = 0; i < NW + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(req, {{(WW-1){1'b0}}, dout_valid}, 1);
        check(req, dout, model[i-2]);
      end
      if (i < NW) go_read(i); else go_idle();
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic read_one(input int a, input string req);
    @(negedge clk); go_read(a);
    @(negedge clk); go_idle();
    @(negedge clk);
    check(req, {{(WW-1){1'b0}}, dout_valid}, 1);
    check(req, dout, model[a]);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; out_en_n = 1'b0; addr = '0; din = '0;
    go_idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {{(WW-1){1'b0}}, dout_valid}, 0);

    // R4: global write with all lane selects off
    for (int a = 0; a < NW; a++) begin
      @(negedge clk); go_write(a, 1'b0, 1'b1, 4'hF, pat(a, 1));
    end
    @(negedge clk); go_idle();
    sweep("R4");

    // R5: every lane mask, one per address
    for (int m = 0; m < 16; m++) begin
      @(negedge clk); go_write(m, 1'b1, 1'b0, 4'(m), pat(m, 2));
    end
    @(negedge clk); go_idle();
    sweep("R5");

    // R6: lane selects low but lane write disabled is a read
    for (int a = 0; a < 4; a++) begin
      @(negedge clk); go_write(a, 1'b1, 1'b1, 4'h0, pat(a, 3));
      @(negedge clk); go_idle();
      @(negedge clk);
      check("R6", {{(WW-1){1'b0}}, dout_valid}, 1);
      check("R6", dout, model[a]);
      repeat (2) @(negedge clk);
    end

    // R2: every partial select combination
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        @(negedge clk);
        go_idle();
        sel_a_n = c[2]; sel_b = c[1]; sel_c_n = c[0];
        addr = 4'd3; din = '1; wr_all_n = 1'b0;
        @(negedge clk);
        wr_all_n = 1'b1;
        @(negedge clk); go_idle();
        @(negedge clk);
        check("R2", {{(WW-1){1'b0}}, dout_valid}, 0);
      end
    end
    read_one(3, "R2");

    // R7: read then deselect
    @(negedge clk); go_read(4);
    @(negedge clk); go_idle();
    @(negedge clk);
    check("R7", {{(WW-1){1'b0}}, dout_valid}, 1);
    check("R7", dout, model[4]);
    @(negedge clk);
    check("R7", {{(WW-1){1'b0}}, dout_valid}, 1);
    check("R7", dout, model[4]);
    @(negedge clk);
    check("R7", {{(WW-1){1'b0}}, dout_valid}, 0);
    // R7: read then selected write
    @(negedge clk); go_read(4);
    @(negedge clk); go_write(8, 1'b0, 1'b1, 4'hF, pat(8, 4));
    @(negedge clk); go_idle();
    check("R7", {{(WW-1){1'b0}}, dout_valid}, 1);
    @(negedge clk);
    check("R7", {{(WW-1){1'b0}}, dout_valid}, 0);
    repeat (2) @(negedge clk);

    // R8: asynchronous output enable
    @(negedge clk); go_read(5);
    @(negedge clk); go_idle();
    @(negedge clk);
    check("R8", {{(WW-1){1'b0}}, dout_valid}, 1);
    out_en_n = 1'b1; #1;
    check("R8", {{(WW-1){1'b0}}, dout_valid}, 0);
    out_en_n = 1'b0; #1;
    check("R8", {{(WW-1){1'b0}}, dout_valid}, 1);
    check("R8", dout, model[5]);
    repeat (2) @(negedge clk);

    // R9: sleep blocks write and read
    @(negedge clk);
    go_idle(); sel_a_n = 1'b0; addr = 4'd6; din = ~model[6];
    wr_all_n = 1'b0; sleep = 1'b1;
    @(negedge clk); wr_all_n = 1'b1;
    @(negedge clk); go_idle();
    @(negedge clk);
    check("R9", {{(WW-1){1'b0}}, dout_valid}, 0);
    read_one(6, "R9");

    // R10: write then read of the same address next edge
    @(negedge clk); go_write(7, 1'b0, 1'b1, 4'hF, pat(7, 5));
    @(negedge clk); go_read(7);
    @(negedge clk); go_idle();
    @(negedge clk);
    check("R10", dout, pat(7, 5));
    repeat (2) @(negedge clk);

    // R11: lane 1 spans bits 9..17
    @(negedge clk); go_write(9, 1'b0, 1'b1, 4'hF, '0);
    @(negedge clk); go_write(9, 1'b1, 1'b0, 4'b1101, '1);
    @(negedge clk); go_read(9);
    @(negedge clk); go_idle();
    @(negedge clk);
    check("R11", dout, 36'h0_0003_FE00);
    repeat (2) @(negedge clk);

    sweep("R5");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule